// File: doc/BRIEF.md
# Host-Slave Byte Mailbox

This block sits between a host processor's byte-wide peripheral bus and a small local controller. The host writes bytes into an input buffer and reads bytes from an output buffer. It can also read a status byte that tells it whether each buffer holds a byte not yet consumed. The local side consumes the input buffer with a read strobe and fills the output buffer with a write strobe. It also owns four user-defined status bits and one general-purpose flag.

The host strobes are asynchronous to the local clock. They pass through a synchronizer, and a host access takes effect only when its strobe is released. On every host write, the address line records whether the byte was a command or plain data. While the host is reading the status byte, changes requested by the local side are parked and applied once that read ends. The host therefore never sees the byte change under its strobe.

Top module: `hs_byte_mailbox`

## Requirements
- R1: After reset the status byte (`loc_status`) is 0x00 and `host_oe` is low.
- R2: A host write with `host_a0`=0 and `host_cs_n` low loads `host_din` into the input buffer (`loc_ibuf_q`). It sets IBF (status bit 1) and clears F1 (status bit 3).
- R3: A host write with `host_a0`=1 loads the input buffer, sets IBF and sets F1 (status bit 3).
- R4: Host strobes act only on their release (rising edge of `host_wr_n` / `host_rd_n`). While a strobe is held low, the input buffer, IBF, F1 and OBF keep their values.
- R5: With `host_cs_n` high, host strobes change neither the buffers nor the status byte, and `host_oe` stays low.
- R6: A local read strobe (`loc_ibuf_re`) clears IBF (status bit 1) one cycle later.
- R7: A local write strobe (`loc_obuf_we`) loads `loc_obuf_d` into the output buffer and sets OBF (status bit 0). A host read with `host_a0`=0 returns the output buffer on `host_dout` and clears OBF after the strobe is released.
- R8: A host read with `host_a0`=1 returns the status byte on `host_dout` and leaves OBF unchanged.
- R9: A status-nibble write (`loc_usr_we`) copies `loc_usr_nib` into status bits 7:4 and leaves bits 3:0 unchanged.
- R10: An F0 write (`loc_f0_we`) sets status bit 2 to `loc_f0_d`.
- R11: While a host status read is in progress, local nibble, F0, IBF-clear and OBF-set requests leave the status byte unchanged. They are applied on the cycle after the synchronized read strobe is released.
- R12: `host_oe` is high exactly while `host_cs_n` and `host_rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address: 0 data/output buffer, 1 command/status |
| host_din | input | DW | Host bus, write direction |
| host_dout | output | DW | Host bus, read direction |
| host_oe | output | 1 | Host bus output enable |
| loc_ibuf_re | input | 1 | Local consume strobe for the input buffer |
| loc_ibuf_q | output | DW | Input buffer contents |
| loc_obuf_we | input | 1 | Local load strobe for the output buffer |
| loc_obuf_d | input | DW | Byte for the output buffer |
| loc_usr_we | input | 1 | Local status-nibble write strobe |
| loc_usr_nib | input | 4 | Value for status bits 7:4 |
| loc_f0_we | input | 1 | Local F0 write strobe |
| loc_f0_d | input | 1 | Value for F0 |
| loc_status | output | DW | Current status byte |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. This lengthens the gap between a strobe release and its effect, so the checks made while a strobe is held low and just after its release are exercised with the longer latency a slower host clock relation would bring. The data width stays at eight, the only width the status layout allows. Random mixes of command and data writes, buffer reads, status reads and deselected accesses are compared against a bench model. A status read held open across parked local updates is run as a directed case.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_F0  = 2;
   localparam int ST_F1  = 3;
   localparam int ST_USR = 4;
   localparam int HSB_DW = 8;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
   parameter int NB = 4,
   parameter int STAGES = 2,
   parameter logic [NB-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] d_in,
   output logic [NB-1:0] d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][NB-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/hsb_host_evt.sv
module hsb_host_evt #(
   parameter int DW = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          a0,
   input  logic [DW-1:0] din,
   output logic          wr_evt,
   output logic          wr_cmd,
   output logic [DW-1:0] wr_data,
   output logic          rd_clr,
   output logic          sts_lock
);
   logic [3:0] s_vec;
   logic s_a0, s_cs_n, s_rd_n, s_wr_n;
   logic wr_p, rd_p, hold_sel, rd_sel, rd_a0;
   logic hold_cmd;
   logic [DW-1:0] hold_dat;

   hsb_sync #(.NB(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_in({a0, cs_n, rd_n, wr_n}),
      .d_out(s_vec)
   );
   assign {s_a0, s_cs_n, s_rd_n, s_wr_n} = s_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p     <= 1'b1;
         rd_p     <= 1'b1;
         hold_sel <= 1'b0;
         hold_cmd <= 1'b0;
         hold_dat <= '0;
         rd_sel   <= 1'b0;
         rd_a0    <= 1'b0;
      end else begin
         wr_p <= s_wr_n;
         rd_p <= s_rd_n;
         if (!s_wr_n) begin
            hold_sel <= !s_cs_n;
            hold_cmd <= s_a0;
            hold_dat <= din;
         end
         if (!s_rd_n) begin
            rd_sel <= !s_cs_n;
            rd_a0  <= s_a0;
         end
      end
   end

   assign wr_evt   = s_wr_n & ~wr_p & hold_sel;
   assign wr_cmd   = hold_cmd;
   assign wr_data  = hold_dat;
   assign rd_clr   = s_rd_n & ~rd_p & rd_sel & ~rd_a0;
   assign sts_lock = ~s_rd_n & ~s_cs_n & s_a0;

   a_r4_wr_evt_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |-> ($past(!s_wr_n) && s_wr_n));
   a_r4_rd_clr_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |-> ($past(!s_rd_n) && s_rd_n));
endmodule

// File: rtl/hsb_status.sv
module hsb_status
   import hsb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_evt,
   input  logic       wr_cmd,
   input  logic       rd_clr,
   input  logic       lock,
   input  logic       ibuf_re,
   input  logic       obuf_we,
   input  logic       usr_we,
   input  logic [3:0] usr_nib,
   input  logic       f0_we,
   input  logic       f0_d,
   output logic [7:0] sts
);
   logic [7:0] sts_q;
   logic       p_usr_v, p_f0_v, p_f0, p_ibf_clr, p_obf_set;
   logic [3:0] p_usr;
   logic       m_usr_v, m_f0_v, m_f0, m_ibf_clr, m_obf_set;
   logic [3:0] m_usr;

   assign m_usr_v   = usr_we | p_usr_v;
   assign m_usr     = usr_we ? usr_nib : p_usr;
   assign m_f0_v    = f0_we | p_f0_v;
   assign m_f0      = f0_we ? f0_d : p_f0;
   assign m_ibf_clr = ibuf_re | p_ibf_clr;
   assign m_obf_set = obuf_we | p_obf_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q     <= '0;
         p_usr_v   <= 1'b0;
         p_usr     <= '0;
         p_f0_v    <= 1'b0;
         p_f0      <= 1'b0;
         p_ibf_clr <= 1'b0;
         p_obf_set <= 1'b0;
      end else begin
         if (lock) begin
            p_usr_v   <= m_usr_v;
            p_usr     <= m_usr;
            p_f0_v    <= m_f0_v;
            p_f0      <= m_f0;
            p_ibf_clr <= m_ibf_clr;
            p_obf_set <= m_obf_set;
         end else begin
            p_usr_v   <= 1'b0;
            p_f0_v    <= 1'b0;
            p_ibf_clr <= 1'b0;
            p_obf_set <= 1'b0;
            if (m_usr_v) sts_q[7:ST_USR] <= m_usr;
            if (m_f0_v)  sts_q[ST_F0]    <= m_f0;
         end
         if (wr_evt) sts_q[ST_F1] <= wr_cmd;
         if (wr_evt)                    sts_q[ST_IBF] <= 1'b1;
         else if (!lock && m_ibf_clr)   sts_q[ST_IBF] <= 1'b0;
         if (!lock && m_obf_set)        sts_q[ST_OBF] <= 1'b1;
         else if (rd_clr)               sts_q[ST_OBF] <= 1'b0;
      end
   end

   assign sts = sts_q;

   a_r2_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> sts_q[ST_IBF]);
   a_r3_f1_tracks_a0: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> (sts_q[ST_F1] == $past(wr_cmd)));
   a_r6_local_read_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
      (ibuf_re && !lock && !wr_evt) |=> !sts_q[ST_IBF]);
   a_r7_data_read_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !obuf_we && !p_obf_set) |=> !sts_q[ST_OBF]);
   a_r9_nibble_write: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_we && !lock) |=> (sts_q[7:ST_USR] == $past(usr_nib)));
   a_r11_lock_holds_status: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !wr_evt && !rd_clr) |=> $stable(sts_q));
endmodule

// File: rtl/hs_byte_mailbox.sv
module hs_byte_mailbox
   import hsb_pkg::*;
#(
   parameter int DW = HSB_DW,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_cs_n,
   input  logic          host_rd_n,
   input  logic          host_wr_n,
   input  logic          host_a0,
   input  logic [DW-1:0] host_din,
   output logic [DW-1:0] host_dout,
   output logic          host_oe,
   input  logic          loc_ibuf_re,
   output logic [DW-1:0] loc_ibuf_q,
   input  logic          loc_obuf_we,
   input  logic [DW-1:0] loc_obuf_d,
   input  logic          loc_usr_we,
   input  logic [3:0]    loc_usr_nib,
   input  logic          loc_f0_we,
   input  logic          loc_f0_d,
   output logic [DW-1:0] loc_status
);
   if (DW != 8) begin : g_bad_dw
      $error("hs_byte_mailbox: status layout needs DW == 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hs_byte_mailbox: SYNC_STAGES must be at least 2");
   end

   logic          wr_evt, wr_cmd, rd_clr, sts_lock;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] ibuf_q, obuf_q;
   logic [7:0]    sts;

   hsb_host_evt #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .cs_n(host_cs_n), .rd_n(host_rd_n), .wr_n(host_wr_n),
      .a0(host_a0), .din(host_din),
      .wr_evt(wr_evt), .wr_cmd(wr_cmd), .wr_data(wr_data),
      .rd_clr(rd_clr), .sts_lock(sts_lock)
   );

   hsb_status u_sts (
      .clk(clk), .rst_n(rst_n),
      .wr_evt(wr_evt), .wr_cmd(wr_cmd), .rd_clr(rd_clr), .lock(sts_lock),
      .ibuf_re(loc_ibuf_re), .obuf_we(loc_obuf_we),
      .usr_we(loc_usr_we), .usr_nib(loc_usr_nib),
      .f0_we(loc_f0_we), .f0_d(loc_f0_d),
      .sts(sts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibuf_q <= '0;
         obuf_q <= '0;
      end else begin
         if (wr_evt)      ibuf_q <= wr_data;
         if (loc_obuf_we) obuf_q <= loc_obuf_d;
      end
   end

   assign loc_ibuf_q = ibuf_q;
   assign loc_status = sts;
   assign host_oe    = ~host_cs_n & ~host_rd_n;
   assign host_dout  = host_a0 ? sts : obuf_q;

   a_r2_ibuf_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> (loc_ibuf_q == $past(wr_data)));
   a_r7_obuf_load: assert property (@(posedge clk) disable iff (!rst_n)
      loc_obuf_we |=> (obuf_q == $past(loc_obuf_d)));
   a_r5_no_event_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs_n && $past(host_cs_n) && !wr_evt) |=> $stable(loc_ibuf_q));
endmodule

// File: tb/hs_byte_mailbox_tb.sv
module hs_byte_mailbox_tb_top;
   localparam int DW = 8;
   localparam int SS = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
   logic [DW-1:0] host_din = '0, host_dout, loc_ibuf_q, loc_obuf_d = '0, loc_status;
   logic host_oe;
   logic loc_ibuf_re = 1'b0, loc_obuf_we = 1'b0, loc_usr_we = 1'b0, loc_f0_we = 1'b0, loc_f0_d = 1'b0;
   logic [3:0] loc_usr_nib = '0;

   int total = 0, bad = 0;
   bit done = 1'b0;
   logic [7:0] m_sts, m_ibuf, m_obuf;

   always #5 clk = ~clk;

   hs_byte_mailbox #(.DW(DW), .SYNC_STAGES(SS)) dut_i (.*);

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sts_after_write(input logic [7:0] s, input logic cmd);
      logic [7:0] r = s;
      r[1] = 1'b1;
      r[3] = cmd;
      return r;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic cs, input logic cmd, input logic [7:0] d);
      @(negedge clk);
      host_cs_n = ~cs; host_a0 = cmd; host_din = d;
      host_wr_n = 1'b0;
      idle(5);
      host_wr_n = 1'b1;
      idle(4);
      host_cs_n = 1'b1;
      idle(SS + 4);
      if (cs) begin
         m_ibuf = d;
         m_sts = sts_after_write(m_sts, cmd);
      end
   endtask

   task automatic host_read(input logic cs, input logic sel_sts, output logic [7:0] got, output logic oe);
      @(negedge clk);
      host_cs_n = ~cs; host_a0 = sel_sts;
      host_rd_n = 1'b0;
      idle(3);
      got = host_dout; oe = host_oe;
      idle(2);
      host_rd_n = 1'b1;
      idle(2);
      host_cs_n = 1'b1;
      idle(SS + 4);
   endtask

   task automatic pulse_loc(input int kind, input logic [7:0] v);
      @(negedge clk);
      case (kind)
         0: loc_ibuf_re = 1'b1;
         1: begin loc_obuf_we = 1'b1; loc_obuf_d = v; end
         2: begin loc_usr_we = 1'b1; loc_usr_nib = v[3:0]; end
         default: begin loc_f0_we = 1'b1; loc_f0_d = v[0]; end
      endcase
      @(negedge clk);
      loc_ibuf_re = 1'b0; loc_obuf_we = 1'b0; loc_usr_we = 1'b0; loc_f0_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] got, exp_d;
      logic oe;
      void'($urandom(32'h5eed_1234));
      m_sts = '0; m_ibuf = '0; m_obuf = '0;
      idle(3);
      chk("R1 status after reset", loc_status, 8'h00);
      chk("R1 oe after reset", {7'b0, host_oe}, 8'h00);
      rst_n = 1'b1;
      idle(3);

      // R2 data write
      host_write(1'b1, 1'b0, 8'h3C);
      chk("R2 ibuf", loc_ibuf_q, 8'h3C);
      chk("R2 status", loc_status, 8'h02);
      // R3 command write
      host_write(1'b1, 1'b1, 8'hC5);
      chk("R3 ibuf", loc_ibuf_q, 8'hC5);
      chk("R3 status F1", loc_status, 8'h0A);
      // R6 local read
      pulse_loc(0, 8'h00); m_sts[1] = 1'b0;
      chk("R6 IBF cleared", loc_status, 8'h08);

      // R4 write held low: nothing changes yet
      @(negedge clk);
      host_cs_n = 1'b0; host_a0 = 1'b0; host_din = 8'h77; host_wr_n = 1'b0;
      idle(SS + 6);
      chk("R4 ibuf held", loc_ibuf_q, 8'hC5);
      chk("R4 status held", loc_status, 8'h08);
      host_wr_n = 1'b1; idle(4); host_cs_n = 1'b1; idle(SS + 4);
      m_ibuf = 8'h77; m_sts = sts_after_write(m_sts, 1'b0);
      chk("R4 applied after release", loc_status, m_sts);

      // R7 output buffer path, with R4 read held low
      pulse_loc(1, 8'h9E); m_obuf = 8'h9E; m_sts[0] = 1'b1;
      chk("R7 OBF set", loc_status, m_sts);
      @(negedge clk);
      host_cs_n = 1'b0; host_a0 = 1'b0; host_rd_n = 1'b0;
      idle(SS + 6);
      chk("R7 dout", host_dout, 8'h9E);
      chk("R12 oe during read", {7'b0, host_oe}, 8'h01);
      chk("R4 OBF held while RD low", loc_status, m_sts);
      host_rd_n = 1'b1; idle(1);
      chk("R12 oe after read", {7'b0, host_oe}, 8'h00);
      idle(1); host_cs_n = 1'b1; idle(SS + 4);
      m_sts[0] = 1'b0;
      chk("R7 OBF cleared", loc_status, m_sts);

      // R9 / R10
      m_sts[2] = 1'b1;
      pulse_loc(3, 8'h01);
      chk("R10 F0 set", loc_status, m_sts);
      pulse_loc(2, 8'h0B); m_sts[7:4] = 4'hB;
      chk("R9 nibble", loc_status, m_sts);

      // R11 lockout: park local updates under a status read
      pulse_loc(1, 8'h21); m_obuf = 8'h21; m_sts[0] = 1'b1;
      pulse_loc(0, 8'h00); m_sts[1] = 1'b0;
      @(negedge clk);
      host_cs_n = 1'b0; host_a0 = 1'b1; host_rd_n = 1'b0;
      idle(SS + 3);
      exp_d = m_sts;
      pulse_loc(2, 8'h05);
      pulse_loc(3, 8'h00);
      pulse_loc(1, 8'h44);
      idle(3);
      chk("R11 status frozen", loc_status, exp_d);
      chk("R11 dout frozen", host_dout, exp_d);
      host_rd_n = 1'b1; idle(2); host_cs_n = 1'b1; idle(SS + 4);
      m_obuf = 8'h44; m_sts[7:4] = 4'h5; m_sts[2] = 1'b0;
      chk("R11 parked updates applied", loc_status, m_sts);
      chk("R8 status read kept OBF", {7'b0, loc_status[0]}, 8'h01);

      // R5 deselected accesses
      host_write(1'b0, 1'b1, 8'hEE);
      chk("R5 write ignored ibuf", loc_ibuf_q, m_ibuf);
      chk("R5 write ignored status", loc_status, m_sts);
      host_read(1'b0, 1'b0, got, oe);
      chk("R5 oe low", {7'b0, oe}, 8'h00);
      chk("R5 read ignored status", loc_status, m_sts);

      // random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [7:0] v;
         logic cs;
         op = $urandom_range(0, 6);
         v  = 8'($urandom);
         cs = ($urandom_range(0, 7) != 0);
         case (op)
            0: host_write(cs, v[0], v);
            1: begin
               exp_d = m_obuf;
               host_read(cs, 1'b0, got, oe);
               if (cs) begin
                  chk("R7 random data read", got, exp_d);
                  m_sts[0] = 1'b0;
               end
               chk("R12 random oe", {7'b0, oe}, {7'b0, cs});
            end
            2: begin
               exp_d = m_sts;
               host_read(cs, 1'b1, got, oe);
               if (cs) chk("R8 random status read", got, exp_d);
            end
            3: begin pulse_loc(0, v); m_sts[1] = 1'b0; end
            4: begin pulse_loc(1, v); m_obuf = v; m_sts[0] = 1'b1; end
            5: begin pulse_loc(2, v); m_sts[7:4] = v[3:0]; end
            default: begin pulse_loc(3, v); m_sts[2] = v[0]; end
         endcase
         idle(1);
         chk("R2 R3 R9 random status", loc_status, m_sts);
         chk("R2 random ibuf", loc_ibuf_q, m_ibuf);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule